// File: doc/BRIEF.md
# Debug Hit Privilege Qualifier

This block sits behind the address comparators of a processor's debug unit. It takes one instruction-breakpoint hit strobe and a parameterised number of data-watchpoint hit strobes. For each hit it decides whether the event may be reported, given the current processor mode (user-level flag, hypervisor flag, data-translation flag). Address comparison is done elsewhere; this block only filters hits by privilege and translation state and attaches the status code that the exception logic records.

The breakpoint is qualified by a 2-bit privilege selector. Each watchpoint has five control bits: a user enable, a hypervisor enable, a supervisor enable, a translation-ignore bit and a required-translation bit. Qualified events are registered and appear in the cycle after the strobe, together with a fixed status word. A feature-enable input blanks the whole block.

Top module: `dbg_hit_qual`

## Requirements
- R1: With breakpoint selector `bp_priv` = 1, a breakpoint strobe is reported only when `ms_pr` = 1.
- R2: With `bp_priv` = 2, a breakpoint strobe is reported only when `ms_pr` = 0 and `ms_hv` = 0.
- R3: With `bp_priv` = 3, a breakpoint strobe is reported only when `ms_pr` = 0 and `ms_hv` = 1.
- R4: With `bp_priv` = 0, no breakpoint strobe is ever reported.
- R5: A watchpoint strobe is rejected when `ms_pr` = 1 and its `wp_pr_en` bit is 0, or when `ms_hv` = 1 and its `wp_hv_en` bit is 0.
- R6: A watchpoint strobe is rejected whenever its `wp_sv_en` bit is 0, in every mode.
- R7: When a watchpoint's `wp_wti` bit is 0, it is reported only if its `wp_wt` bit equals `ms_dr`.
- R8: When a watchpoint's `wp_wti` bit is 1, `ms_dr` and `wp_wt` have no effect on the decision.
- R9: While `bp_evt` is 1, `bp_status` has bits 33 and 43 set and all other bits clear. Bits are numbered from the MSB as bit 0, so with `STATUS_W` = 64 the value is 0x0000_0000_4010_0000. While `bp_evt` is 0, `bp_status` is zero.
- R10: While any `wp_evt` bit is 1, `wp_status` has only bit 41 set, numbered from the MSB as bit 0 (0x0000_0000_0040_0000 at 64 bits). Otherwise `wp_status` is zero.
- R11: While `feat_en` is 0, all outputs are zero in the same cycle, and strobes taken while it is 0 produce no event later.
- R12: A qualified strobe sampled at a rising clock edge drives its event output high for exactly the following cycle. A strobe held for N cycles gives N event cycles, and a cycle without a strobe gives no event.
- R13: During and right after reset, all event and status outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Block enable; 0 blanks all outputs |
| ms_pr | input | 1 | User-level (problem) state flag |
| ms_hv | input | 1 | Hypervisor state flag |
| ms_dr | input | 1 | Data-translation enabled flag |
| bp_hit | input | 1 | Breakpoint address-match strobe |
| bp_priv | input | 2 | Breakpoint privilege selector (0 off, 1 user, 2 supervisor, 3 hypervisor) |
| wp_hit | input | NUM_WPT | Watchpoint address-match strobes |
| wp_wt | input | NUM_WPT | Required translation state per watchpoint |
| wp_wti | input | NUM_WPT | Ignore translation state per watchpoint |
| wp_hv_en | input | NUM_WPT | Allow in hypervisor state |
| wp_sv_en | input | NUM_WPT | Supervisor enable (required in all modes) |
| wp_pr_en | input | NUM_WPT | Allow in user-level state |
| bp_evt | output | 1 | Qualified breakpoint event pulse |
| bp_status | output | STATUS_W | Breakpoint status code |
| wp_evt | output | NUM_WPT | Qualified watchpoint event pulses |
| wp_status | output | STATUS_W | Watchpoint status code |

## Verification
The bench builds the block with its defaults: two watchpoint channels and a 64-bit status word, with the status bits at positions 33, 43 and 41. Two channels show that a strobe on one channel never raises the other. The 64-bit width places every status bit at its architectural MSB-first position, so the fixed 0x4010_0000 and 0x0040_0000 patterns can be checked directly. The breakpoint selector, the mode flags and all five watchpoint control bits are small enough to sweep exhaustively.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;

   typedef enum logic [1:0] {
      BPSEL_OFF   = 2'd0,
      BPSEL_USER  = 2'd1,
      BPSEL_SUPER = 2'd2,
      BPSEL_HYPER = 2'd3
   } bp_sel_e;

   typedef struct packed {
      logic pr;
      logic hv;
      logic dr;
   } mode_t;

   typedef struct packed {
      logic wt;
      logic wti;
      logic hv_en;
      logic sv_en;
      logic pr_en;
   } wp_ctl_t;

endpackage

// File: rtl/dbgq_bp_qual.sv
module dbgq_bp_qual
   import dbgq_pkg::*;
(
   input  logic       hit_i,
   input  logic [1:0] sel_i,
   input  mode_t      mode_i,
   output logic       ok_o
);

   logic allowed;

   always_comb begin
      unique case (bp_sel_e'(sel_i))
         BPSEL_USER:  allowed = mode_i.pr;
         BPSEL_SUPER: allowed = !mode_i.pr && !mode_i.hv;
         BPSEL_HYPER: allowed = !mode_i.pr &&  mode_i.hv;
         default:     allowed = 1'b0;
      endcase
   end

   assign ok_o = hit_i && allowed;

endmodule

// File: rtl/dbgq_wp_qual.sv
module dbgq_wp_qual
   import dbgq_pkg::*;
(
   input  logic    hit_i,
   input  wp_ctl_t ctl_i,
   input  mode_t   mode_i,
   output logic    ok_o
);

   logic veto;
   logic xlat_ok;

   always_comb begin
      veto = 1'b0;
      if (mode_i.pr && !ctl_i.pr_en) veto = 1'b1;
      if (mode_i.hv && !ctl_i.hv_en) veto = 1'b1;
      if (!ctl_i.sv_en)              veto = 1'b1;
   end

   always_comb begin
      if (ctl_i.wti) xlat_ok = 1'b1;
      else           xlat_ok = (ctl_i.wt == mode_i.dr);
   end

   assign ok_o = hit_i && !veto && xlat_ok;

endmodule

// File: rtl/dbgq_evt_reg.sv
module dbgq_evt_reg #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= en_i ? d_i : '0;
   end

   assign q_o = q_r & {W{en_i}};

endmodule

// File: rtl/dbg_hit_qual.sv
module dbg_hit_qual
   import dbgq_pkg::*;
#(
   parameter int NUM_WPT  = 2,
   parameter int STATUS_W = 64,
   parameter int BP_BIT_A = 33,
   parameter int BP_BIT_B = 43,
   parameter int WP_BIT   = 41
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                feat_en,
   input  logic                ms_pr,
   input  logic                ms_hv,
   input  logic                ms_dr,
   input  logic                bp_hit,
   input  logic [1:0]          bp_priv,
   input  logic [NUM_WPT-1:0]  wp_hit,
   input  logic [NUM_WPT-1:0]  wp_wt,
   input  logic [NUM_WPT-1:0]  wp_wti,
   input  logic [NUM_WPT-1:0]  wp_hv_en,
   input  logic [NUM_WPT-1:0]  wp_sv_en,
   input  logic [NUM_WPT-1:0]  wp_pr_en,
   output logic                bp_evt,
   output logic [STATUS_W-1:0] bp_status,
   output logic [NUM_WPT-1:0]  wp_evt,
   output logic [STATUS_W-1:0] wp_status
);

   localparam int EVT_W = NUM_WPT + 1;
   localparam logic [STATUS_W-1:0] ONE = {{(STATUS_W-1){1'b0}}, 1'b1};
   localparam logic [STATUS_W-1:0] BP_CODE =
      (ONE << (STATUS_W - 1 - BP_BIT_A)) | (ONE << (STATUS_W - 1 - BP_BIT_B));
   localparam logic [STATUS_W-1:0] WP_CODE = ONE << (STATUS_W - 1 - WP_BIT);

   generate
      if (NUM_WPT < 1)
         $error("NUM_WPT must be at least 1");
      if (BP_BIT_A >= STATUS_W || BP_BIT_B >= STATUS_W || WP_BIT >= STATUS_W)
         $error("status bit position outside STATUS_W");
      if (BP_BIT_A == BP_BIT_B)
         $error("breakpoint status bits must differ");
   endgenerate

   mode_t mode;
   assign mode = '{pr: ms_pr, hv: ms_hv, dr: ms_dr};

   logic [EVT_W-1:0] ok_vec;
   logic [EVT_W-1:0] evt_vec;

   dbgq_bp_qual u_bp (
      .hit_i  (bp_hit),
      .sel_i  (bp_priv),
      .mode_i (mode),
      .ok_o   (ok_vec[0])
   );

   genvar g;
   generate
      for (g = 0; g < NUM_WPT; g++) begin : g_wp
         wp_ctl_t ctl;
         assign ctl = '{wt: wp_wt[g], wti: wp_wti[g], hv_en: wp_hv_en[g],
                        sv_en: wp_sv_en[g], pr_en: wp_pr_en[g]};
         dbgq_wp_qual u_wp (
            .hit_i  (wp_hit[g]),
            .ctl_i  (ctl),
            .mode_i (mode),
            .ok_o   (ok_vec[g+1])
         );
      end
   endgenerate

   dbgq_evt_reg #(.W(EVT_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (feat_en),
      .d_i   (ok_vec),
      .q_o   (evt_vec)
   );

   assign bp_evt    = evt_vec[0];
   assign wp_evt    = evt_vec[EVT_W-1:1];
   assign bp_status = bp_evt    ? BP_CODE : '0;
   assign wp_status = |wp_evt   ? WP_CODE : '0;

endmodule

// File: rtl/dbgq_checker.sv
module dbgq_checker #(
   parameter int NUM_WPT  = 2,
   parameter int STATUS_W = 64,
   parameter int BP_BIT_A = 33,
   parameter int BP_BIT_B = 43,
   parameter int WP_BIT   = 41
) (
   input logic                clk,
   input logic                rst_n,
   input logic                feat_en,
   input logic                ms_pr,
   input logic                ms_hv,
   input logic                ms_dr,
   input logic                bp_hit,
   input logic [1:0]          bp_priv,
   input logic [NUM_WPT-1:0]  wp_hit,
   input logic [NUM_WPT-1:0]  wp_wt,
   input logic [NUM_WPT-1:0]  wp_wti,
   input logic [NUM_WPT-1:0]  wp_sv_en,
   input logic                bp_evt,
   input logic [STATUS_W-1:0] bp_status,
   input logic [NUM_WPT-1:0]  wp_evt,
   input logic [STATUS_W-1:0] wp_status
);

   localparam logic [STATUS_W-1:0] UNIT = {{(STATUS_W-1){1'b0}}, 1'b1};
   localparam logic [STATUS_W-1:0] EXP_BP =
      (UNIT << (STATUS_W - 1 - BP_BIT_A)) | (UNIT << (STATUS_W - 1 - BP_BIT_B));
   localparam logic [STATUS_W-1:0] EXP_WP = UNIT << (STATUS_W - 1 - WP_BIT);

   AST_BP_USER_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (feat_en && bp_hit && bp_priv == 2'd1 && ms_pr) |=> (bp_evt || !feat_en)); // R1
   AST_BP_USER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_priv == 2'd1 && !ms_pr) |=> !bp_evt); // R1
   AST_BP_SUPER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_priv == 2'd2 && (ms_pr || ms_hv)) |=> !bp_evt); // R2
   AST_BP_HYPER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_priv == 2'd3 && (ms_pr || !ms_hv)) |=> !bp_evt); // R3
   AST_BP_OFF_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_priv == 2'd0) |=> !bp_evt); // R4
   AST_BP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      bp_status == (bp_evt ? EXP_BP : '0)); // R9
   AST_WP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      wp_status == ((|wp_evt) ? EXP_WP : '0)); // R10
   AST_FEAT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      !feat_en |-> (!bp_evt && wp_evt == '0 && bp_status == '0 && wp_status == '0)); // R11
   AST_NO_STROBE_BP: assert property (@(posedge clk) disable iff (!rst_n)
      !bp_hit |=> !bp_evt); // R12

   genvar c;
   generate
      for (c = 0; c < NUM_WPT; c++) begin : g_chk
         AST_WP_SV_VETO: assert property (@(posedge clk) disable iff (!rst_n)
            !wp_sv_en[c] |=> !wp_evt[c]); // R6
         AST_WP_XLAT_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (!wp_wti[c] && wp_wt[c] != ms_dr) |=> !wp_evt[c]); // R7
         AST_NO_STROBE_WP: assert property (@(posedge clk) disable iff (!rst_n)
            !wp_hit[c] |=> !wp_evt[c]); // R12
      end
   endgenerate

endmodule

bind dbg_hit_qual dbgq_checker #(
   .NUM_WPT  (NUM_WPT),
   .STATUS_W (STATUS_W),
   .BP_BIT_A (BP_BIT_A),
   .BP_BIT_B (BP_BIT_B),
   .WP_BIT   (WP_BIT)
) u_dbgq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .feat_en   (feat_en),
   .ms_pr     (ms_pr),
   .ms_hv     (ms_hv),
   .ms_dr     (ms_dr),
   .bp_hit    (bp_hit),
   .bp_priv   (bp_priv),
   .wp_hit    (wp_hit),
   .wp_wt     (wp_wt),
   .wp_wti    (wp_wti),
   .wp_sv_en  (wp_sv_en),
   .bp_evt    (bp_evt),
   .bp_status (bp_status),
   .wp_evt    (wp_evt),
   .wp_status (wp_status)
);

// File: tb/test_dbg_hit_qual.sv
`timescale 1ns/1ps
module test_dbg_hit_qual;

   localparam int NW = 2;
   localparam int SW = 64;
   localparam logic [63:0] BP_EXP = 64'h0000_0000_4010_0000;
   localparam logic [63:0] WP_EXP = 64'h0000_0000_0040_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          feat_en = 1'b1;
   logic          ms_pr = 1'b0, ms_hv = 1'b0, ms_dr = 1'b0;
   logic          bp_hit = 1'b0;
   logic [1:0]    bp_priv = 2'd0;
   logic [NW-1:0] wp_hit = '0, wp_wt = '0, wp_wti = '0;
   logic [NW-1:0] wp_hv_en = '0, wp_sv_en = '0, wp_pr_en = '0;
   logic          bp_evt;
   logic [SW-1:0] bp_status, wp_status;
   logic [NW-1:0] wp_evt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dbg_hit_qual i_dbg_hit_qual (
      .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
      .ms_pr(ms_pr), .ms_hv(ms_hv), .ms_dr(ms_dr),
      .bp_hit(bp_hit), .bp_priv(bp_priv),
      .wp_hit(wp_hit), .wp_wt(wp_wt), .wp_wti(wp_wti),
      .wp_hv_en(wp_hv_en), .wp_sv_en(wp_sv_en), .wp_pr_en(wp_pr_en),
      .bp_evt(bp_evt), .bp_status(bp_status),
      .wp_evt(wp_evt), .wp_status(wp_status)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bp_strobe(input logic [1:0] pv, input logic pr, input logic hv,
                            input logic exp, input string req);
      @(negedge clk);
      bp_priv = pv; ms_pr = pr; ms_hv = hv; bp_hit = 1'b1;
      @(negedge clk);
      bp_hit = 1'b0;
      chk(bp_evt === exp, req, 64'(bp_evt), 64'(exp));
      chk(bp_status === (exp ? BP_EXP : 64'h0), "R9", bp_status, exp ? BP_EXP : 64'h0);
   endtask

   task automatic wp_strobe(input int ch, input logic wt, input logic wti,
                            input logic hve, input logic sve, input logic pre,
                            input logic pr, input logic hv, input logic dr,
                            input logic exp, input string req);
      logic [NW-1:0] want;
      @(negedge clk);
      wp_wt = '0; wp_wti = '0; wp_hv_en = '0; wp_sv_en = '0; wp_pr_en = '0;
      wp_wt[ch] = wt; wp_wti[ch] = wti; wp_hv_en[ch] = hve;
      wp_sv_en[ch] = sve; wp_pr_en[ch] = pre;
      ms_pr = pr; ms_hv = hv; ms_dr = dr;
      wp_hit = '0; wp_hit[ch] = 1'b1;
      @(negedge clk);
      wp_hit = '0;
      want = '0; want[ch] = exp;
      chk(wp_evt === want, req, 64'(wp_evt), 64'(want));
      chk(wp_status === (exp ? WP_EXP : 64'h0), "R10", wp_status, exp ? WP_EXP : 64'h0);
   endtask

   task automatic t_reset();
      #1;
      chk(bp_evt === 1'b0 && wp_evt === '0, "R13 evt in reset", 64'({bp_evt, wp_evt}), 64'h0);
      chk(bp_status === '0 && wp_status === '0, "R13 status in reset", bp_status | wp_status, 64'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(bp_evt === 1'b0 && wp_evt === '0, "R13 evt after reset", 64'({bp_evt, wp_evt}), 64'h0);
   endtask

   task automatic t_bp_modes();
      for (int pv = 0; pv < 4; pv++)
         for (int pr = 0; pr < 2; pr++)
            for (int hv = 0; hv < 2; hv++) begin
               logic e;
               string r;
               case (pv)
                  1: begin e = (pr == 1);            r = "R1"; end
                  2: begin e = (pr == 0 && hv == 0); r = "R2"; end
                  3: begin e = (pr == 0 && hv == 1); r = "R3"; end
                  default: begin e = 1'b0;           r = "R4"; end
               endcase
               bp_strobe(2'(pv), pr[0], hv[0], e, r);
            end
   endtask

   task automatic t_wp_enables();
      for (int ch = 0; ch < NW; ch++)
         for (int v = 0; v < 32; v++) begin
            logic hve, sve, pre, pr, hv, e;
            string r;
            {hve, sve, pre, pr, hv} = 5'(v);
            e = 1'b1; r = "R5";
            if ((pr && !pre) || (hv && !hve)) e = 1'b0;
            if (!sve) begin e = 1'b0; r = "R6"; end
            wp_strobe(ch, 1'b0, 1'b1, hve, sve, pre, pr, hv, v[0] ^ v[2], e, r);
         end
   endtask

   task automatic t_wp_translation();
      for (int ch = 0; ch < NW; ch++)
         for (int v = 0; v < 16; v++) begin
            logic wti, wt, dr, pr, e;
            string r;
            {wti, wt, dr, pr} = 4'(v);
            if (wti) begin e = 1'b1; r = "R8"; end
            else     begin e = (wt == dr); r = "R7"; end
            wp_strobe(ch, wt, wti, 1'b1, 1'b1, 1'b1, pr, v[1], dr, e, r);
         end
   endtask

   task automatic t_feature_off();
      @(negedge clk);
      feat_en = 1'b0;
      bp_strobe(2'd1, 1'b1, 1'b0, 1'b0, "R11 bp while off");
      wp_strobe(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 wp while off");
      @(negedge clk);
      feat_en = 1'b1;
      @(negedge clk);
      chk(bp_evt === 1'b0 && wp_evt === '0, "R11 no late event", 64'({bp_evt, wp_evt}), 64'h0);
      @(negedge clk);
      bp_priv = 2'd1; ms_pr = 1'b1; bp_hit = 1'b1;
      @(negedge clk);
      bp_hit = 1'b0; feat_en = 1'b0;
      #1;
      chk(bp_evt === 1'b0 && bp_status === '0, "R11 same-cycle blank",
          64'(bp_evt), 64'h0);
      @(negedge clk);
      feat_en = 1'b1;
   endtask

   task automatic t_pulse();
      @(negedge clk);
      bp_priv = 2'd1; ms_pr = 1'b1; ms_hv = 1'b0; bp_hit = 1'b0;
      @(negedge clk);
      chk(bp_evt === 1'b0, "R12 no strobe", 64'(bp_evt), 64'h0);
      bp_hit = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(bp_evt === 1'b1, "R12 held strobe", 64'(bp_evt), 64'h1);
      end
      bp_hit = 1'b0;
      @(negedge clk);
      chk(bp_evt === 1'b0, "R12 end of pulse", 64'(bp_evt), 64'h0);
      bp_hit = 1'b1;
      @(negedge clk);
      bp_hit = 1'b0;
      chk(bp_evt === 1'b1, "R12 single strobe", 64'(bp_evt), 64'h1);
      @(negedge clk);
      chk(bp_evt === 1'b0, "R12 single cycle", 64'(bp_evt), 64'h0);
   endtask

   initial begin
      t_reset();
      t_bp_modes();
      t_wp_enables();
      t_wp_translation();
      t_feature_off();
      t_pulse();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule